// File: doc/BRIEF.md
# Ramp Converter Capture Timer

This block is the digital side of a single-slope analog-to-digital converter used for motor-control sampling. One shared counter is restarted by every PWM synchronisation pulse while an external ramp voltage rises from its reset level. Each of several comparators watches the ramp against its own analog input. When a comparator first goes high in a period, the counter value at that moment is taken as that channel's conversion result.

The comparator outputs arrive without any clock relationship, so each one is synchronised before use. The counter can advance on every clock or on every second clock, which trades resolution against the full-scale range in a given PWM period. Results for all channels are published together at the next synchronisation pulse, and a one-cycle done strobe marks the update. A reader therefore always sees one coherent set from a single period.

Top module: `ramp_adc_timer`

## Requirements
- R1: While and after reset, and until the first synchronisation pulse, every result field reads 0 and `conv_done` is low.
- R2: A clock cycle with `pwm_sync` high restarts the counter at 0. With `half_rate` low, the counter then increases by one at every following edge, so it holds k after the k-th edge counted from the sync edge.
- R3: With `half_rate` high, the counter holds floor(k/2) after the k-th edge counted from the sync edge. It advances on the 2nd, 4th, 6th and later edges.
- R4: The counter stops at the full-scale value 2^CW-1 and stays there until the next sync pulse.
- R5: A comparator input passes through two synchronising flops. When it rises after the negative clock edge that follows edge d (counted from the sync edge), the channel captures the counter value present after edge d+2.
- R6: Only the first synchronised rising edge in a period is captured. Later rises in the same period are ignored. A rise that becomes visible in the sync cycle itself belongs to no period and is ignored.
- R7: A channel with no captured rise in a period reports full scale (2^CW-1) for that period.
- R8: All result fields change only at a sync edge, and they change together. `conv_done` is high for exactly the one cycle after each sync edge.
- R9: Channel i's result occupies bits [i*CW +: CW] of `result_flat`. Channels capture independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_sync | input | 1 | One-cycle PWM period start; restarts counter and publishes results |
| half_rate | input | 1 | 1: counter advances every second cycle; 0: every cycle |
| cmp_in | input | NCH | Asynchronous comparator outputs, one per channel |
| result_flat | output | NCH*CW | Published results, channel i at [i*CW +: CW] |
| conv_done | output | 1 | One-cycle strobe after results are published |

## Verification
The capture function is driven with comparator trips at different delays on every channel, at both counting rates. This separates the latency of the synchroniser from the prescaler's halving. Channels that never trip, and periods long enough to pass full scale, distinguish the no-trip substitution from counter saturation. Repeated rises within one period check that only the first is kept. Trips placed one cycle either side of the last capturable slot pin down the boundary at which a rise is lost to the sync cycle.

// File: rtl/rat_pkg.sv
package rat_pkg;
  parameter int RAT_NCH = 4;
  parameter int RAT_CW  = 12;

  typedef enum logic {RATE_FULL = 1'b0, RATE_HALF = 1'b1} rate_e;
endpackage

// File: rtl/rat_sync.sv
module rat_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_async[i];
        stab_q <= meta_q;
      end
    end
    assign q_sync[i] = stab_q;
  end
endmodule

// File: rtl/rat_timer.sv
module rat_timer
  import rat_pkg::*;
#(
  parameter int CW = RAT_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_pulse,
  input  logic          half_rate,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  rate_e         rate;
  logic          phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick;

  assign rate = rate_e'(half_rate);
  assign tick = (rate == RATE_FULL) || phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (sync_pulse) begin
      phase_d = 1'b0;
      cnt_d   = '0;
    end else begin
      phase_d = ~phase_q;
      if (tick && (cnt_q != FULL)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign count = cnt_q;

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> (cnt_q == '0));
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_pulse && cnt_q == FULL) |=> (cnt_q == FULL));
endmodule

// File: rtl/rat_channel.sv
module rat_channel #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_s,
  input  logic          sync_pulse,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] result
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic          prev_q;
  logic          trip_q, trip_d;
  logic [CW-1:0] shadow_q, shadow_d;
  logic [CW-1:0] res_q, res_d;
  logic          rise;

  assign rise = cmp_s & ~prev_q;

  always_comb begin
    trip_d   = trip_q;
    shadow_d = shadow_q;
    res_d    = res_q;
    if (sync_pulse) begin
      trip_d = 1'b0;
      res_d  = trip_q ? shadow_q : FULL;
    end else if (rise && !trip_q) begin
      trip_d   = 1'b1;
      shadow_d = count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      trip_q   <= 1'b0;
      shadow_q <= '0;
      res_q    <= '0;
    end else begin
      prev_q   <= cmp_s;
      trip_q   <= trip_d;
      shadow_q <= shadow_d;
      res_q    <= res_d;
    end
  end

  assign result = res_q;

  a_r6_first_only: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && !sync_pulse) |=> (trip_q && $stable(shadow_q)));
  a_r7_fullscale: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && !trip_q) |=> (res_q == FULL));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> $stable(res_q));
endmodule

// File: rtl/ramp_adc_timer.sv
module ramp_adc_timer
  import rat_pkg::*;
#(
  parameter int NCH = RAT_NCH,
  parameter int CW  = RAT_CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_sync,
  input  logic            half_rate,
  input  logic [NCH-1:0]  cmp_in,
  output logic [NCH*CW-1:0] result_flat,
  output logic            conv_done
);
  logic [NCH-1:0] cmp_s;
  logic [CW-1:0]  count;
  logic           done_q, done_d;

  rat_sync #(.W(NCH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_in),
    .q_sync  (cmp_s)
  );

  rat_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_pulse (pwm_sync),
    .half_rate  (half_rate),
    .count      (count)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    rat_channel #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_s      (cmp_s[i]),
      .sync_pulse (pwm_sync),
      .count      (count),
      .result     (result_flat[i*CW +: CW])
    );
  end

  assign done_d = pwm_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign conv_done = done_q;

  a_r8_done_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_sync |=> conv_done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_sync |=> !conv_done);
endmodule

// File: tb/tb_ramp_adc_timer.sv
module tb_ramp_adc_timer;
  localparam int NCH  = 4;
  localparam int CW   = 12;
  localparam int MAXV = (1 << CW) - 1;

  logic              clk;
  logic              rst_n;
  logic              pwm_sync;
  logic              half_rate;
  logic [NCH-1:0]    cmp_in;
  logic [NCH*CW-1:0] result_flat;
  logic              conv_done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int stab_err = 0;
  bit seen_first = 0;
  logic [NCH*CW-1:0] last_pub;

  logic [NCH*CW-1:0] exp_q[$];
  string             tag_q[$];

  ramp_adc_timer dut (
    .clk(clk), .rst_n(rst_n), .pwm_sync(pwm_sync), .half_rate(half_rate),
    .cmp_in(cmp_in), .result_flat(result_flat), .conv_done(conv_done)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_done) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 unexpected conv_done", 1, 0);
        end else begin
          logic [NCH*CW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          for (int i = 0; i < NCH; i++) begin
            int a, x;
            a = int'(result_flat[i*CW +: CW]);
            x = int'(e[i*CW +: CW]);
            check(a == x, $sformatf("%s %s R9 ch%0d", t, (x == MAXV) ? "R7" : "R5", i), a, x);
          end
          last_pub = result_flat;
          seen_first = 1;
        end
      end else if (seen_first && result_flat != last_pub) begin
        stab_err++;
      end
    end
  end

  // driver: schedules one PWM period and pushes its expected results
  task automatic run_period(input bit half, input int len, input int d [NCH],
                            input int dbl_ch, input string tag);
    logic [NCH*CW-1:0] e;
    for (int i = 0; i < NCH; i++) begin
      int v;
      if (d[i] < 0 || d[i] > len - 4) v = MAXV;
      else begin
        v = half ? (d[i] + 2) / 2 : d[i] + 2;
        if (v > MAXV) v = MAXV;
      end
      e[i*CW +: CW] = CW'(v);
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int c = 0; c < len; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == 0) begin
        pwm_sync  = 0;
        half_rate = half;
      end
      for (int i = 0; i < NCH; i++) begin
        if (d[i] == c) cmp_in[i] = 1'b1;
        if (i == dbl_ch && c == d[i] + 3) cmp_in[i] = 1'b0;
        if (i == dbl_ch && c == d[i] + 6) cmp_in[i] = 1'b1;
      end
      if (c == len - 1) begin
        cmp_in   = '0;
        pwm_sync = 1;
      end
    end
  endtask

  task automatic finish_run();
    check(stab_err == 0, "R8 results stable between syncs", stab_err, 0);
    check(exp_q.size() == 0, "R8 all periods published", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; pwm_sync = 0; half_rate = 0; cmp_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(result_flat == '0, "R1 results in reset", int'(result_flat[CW-1:0]), 0);
    check(conv_done == 0, "R1 done in reset", conv_done, 0);
    rst_n = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(result_flat == '0, "R1 results before first sync", int'(result_flat[CW-1:0]), 0);
    check(conv_done == 0, "R1 done before first sync", conv_done, 0);

    exp_q.push_back({NCH*CW{1'b1}});
    tag_q.push_back("R7 first sync");
    pwm_sync = 1;
    // R2 R5 R9: full rate, distinct delays
    run_period(0, 40, '{3, 10, 0, 20}, -1, "R2");
    // R3: half rate
    run_period(1, 40, '{3, 10, 0, 21}, -1, "R3");
    // R7: channels that never trip
    run_period(0, 40, '{5, -1, 7, -1}, -1, "R7");
    // R6: second rise on channel 0 ignored
    run_period(0, 40, '{2, 15, 16, 17}, 0, "R6");
    // R4: saturation in a long period
    run_period(0, 4200, '{4100, 10, -1, 4000}, -1, "R4");
    // R6: last capturable slot vs rise in sync cycle
    run_period(0, 30, '{26, 27, -1, 0}, -1, "R6 boundary");
    // R3 boundary at half rate
    run_period(1, 30, '{26, 1, 2, -1}, -1, "R3 boundary");
    @(posedge clk);
    @(negedge clk);
    pwm_sync = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule